// File: doc/BRIEF.md
# Segment Table Address Translator

This block maps a virtual address onto a physical address through a small table of segment descriptors. The upper bits of the virtual address pick one descriptor and the lower bits are the offset into that segment. Each descriptor carries a valid bit, a physical base address, a bound (the segment length), and four flags: read, write, execute and user-accessible. An access succeeds when the selected descriptor is valid, the offset lies below the bound, and both the privilege level and the access type are allowed. The physical address is then the base plus the offset. Any failed check produces a fault with a cause code instead of an address.

Supervisor software loads descriptors through a write port. A write is accepted only while the supervisor qualifier is high. A memory pipeline sends one access per cycle: an address, an access type and a user/supervisor flag. The result is registered and appears one clock after the request.

Top module: `seg_xlate`

## Requirements
- R1: After reset every descriptor is invalid and `rsp_valid` is low.
- R2: A request in cycle N produces a response in cycle N+1 with `rsp_paddr` = base + offset. The offset is `req_vaddr[OFF_W-1:0]` and the index is `req_vaddr[OFF_W+IDX_W-1:OFF_W]`.
- R3: An offset equal to or above the bound faults with cause 2. A bound of 0 faults every offset, and a bound of 2^OFF_W admits every offset.
- R4: A write access (`req_acc`=1) to a segment without the write flag (`wr_flags[1]`) faults with cause 3. A read (`req_acc`=0) needs the read flag (`wr_flags[0]`).
- R5: An execute access (`req_acc`=2) needs the execute flag (`wr_flags[2]`). `req_acc`=3 is reserved and always faults with cause 3.
- R6: A user access (`req_user`=1) to a segment without the user flag (`wr_flags[3]`) faults with cause 4. A supervisor access ignores that flag.
- R7: An access to an invalid descriptor faults with cause 1.
- R8: When several checks fail, the reported cause follows this priority: invalid (1), then bound (2), then user (4), then permission (3). `rsp_fault` is high exactly when the cause is nonzero.
- R9: A descriptor write with `wr_sup` low is ignored.
- R10: A descriptor write takes effect for the next cycle's access. An access in the same cycle as a write to its entry uses the old contents.
- R11: A cycle without a request gives `rsp_valid` low in the following cycle.
- R12: A faulting response drives `rsp_paddr` to zero.
- R13: The addition of base and offset wraps modulo 2^PA_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Descriptor write strobe |
| wr_sup | input | 1 | Supervisor qualifier for the write |
| wr_idx | input | IDX_W | Descriptor index to write |
| wr_valid | input | 1 | New valid bit |
| wr_base | input | PA_W | New physical base |
| wr_bound | input | OFF_W+1 | New bound (segment length) |
| wr_flags | input | 4 | New flags {user, exec, write, read} |
| req_valid | input | 1 | Access request strobe |
| req_vaddr | input | IDX_W+OFF_W | Virtual address |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 exec, 3 reserved |
| req_user | input | 1 | Access is made from user mode |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 1 | Access faulted |
| rsp_cause | output | 3 | Fault cause: 0 none, 1 invalid, 2 bound, 3 permission, 4 user |
| rsp_paddr | output | PA_W | Physical address, zero on fault |

## Verification
The assertions check on every cycle that a response follows each request and only a request, that the fault flag matches a nonzero cause, that a fault gives a zero address, and that an invalid or out-of-bound lookup gives causes 1 and 2 respectively. The ordering between the user and permission causes needs the bench's scenarios. So do the ignored unprivileged writes, the rule that a write in the same cycle as an access takes effect only afterwards, address wrap, and the exact sum of base and offset. The bench shows these by comparing against its behavioural descriptor model on every cycle.

// File: rtl/seg_pkg.sv
package seg_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_INVALID = 3'd1,
        FLT_BOUND   = 3'd2,
        FLT_PERM    = 3'd3,
        FLT_USER    = 3'd4
    } flt_e;

    localparam int FLAG_W_BITS = 4;
    localparam int FLAG_RD  = 0;
    localparam int FLAG_WR  = 1;
    localparam int FLAG_EX  = 2;
    localparam int FLAG_USR = 3;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
    parameter int IDX_W = 2,
    parameter int PA_W  = 16,
    parameter int BND_W = 13
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic                          wr_valid,
    input  logic [PA_W-1:0]               wr_base,
    input  logic [BND_W-1:0]              wr_bound,
    input  logic [seg_pkg::FLAG_W_BITS-1:0] wr_flags,
    input  logic [IDX_W-1:0]              rd_idx,
    output logic                          rd_valid,
    output logic [PA_W-1:0]               rd_base,
    output logic [BND_W-1:0]              rd_bound,
    output logic [seg_pkg::FLAG_W_BITS-1:0] rd_flags
);
    localparam int NENT = 1 << IDX_W;

    typedef struct packed {
        logic                            valid;
        logic [PA_W-1:0]                 base;
        logic [BND_W-1:0]                bound;
        logic [seg_pkg::FLAG_W_BITS-1:0] flags;
    } desc_t;

    desc_t tab_d [NENT];
    desc_t tab_q [NENT];
    desc_t new_desc;

    always_comb begin
        new_desc.valid = wr_valid;
        new_desc.base  = wr_base;
        new_desc.bound = wr_bound;
        new_desc.flags = wr_flags;
    end

    for (genvar g = 0; g < NENT; g++) begin : g_ent
        always_comb begin
            tab_d[g] = tab_q[g];
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                tab_d[g] = new_desc;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tab_q[g] <= '0;
            end else begin
                tab_q[g] <= tab_d[g];
            end
        end
    end

    // Lookup reads the registered contents: a same-cycle write is not visible.
    always_comb begin
        rd_valid = tab_q[rd_idx].valid;
        rd_base  = tab_q[rd_idx].base;
        rd_bound = tab_q[rd_idx].bound;
        rd_flags = tab_q[rd_idx].flags;
    end

endmodule

// File: rtl/seg_check.sv
module seg_check #(
    parameter int OFF_W = 12,
    parameter int PA_W  = 16,
    parameter int BND_W = OFF_W + 1
) (
    input  logic [OFF_W-1:0]                off,
    input  seg_pkg::acc_e                   acc,
    input  logic                            user,
    input  logic                            d_valid,
    input  logic [PA_W-1:0]                 d_base,
    input  logic [BND_W-1:0]                d_bound,
    input  logic [seg_pkg::FLAG_W_BITS-1:0] d_flags,
    output logic                            fault,
    output seg_pkg::flt_e                   cause,
    output logic [PA_W-1:0]                 paddr
);
    import seg_pkg::*;

    logic             perm_ok;
    logic [BND_W-1:0] off_ext;

    always_comb begin
        off_ext = BND_W'(off);
        unique case (acc)
            ACC_READ:  perm_ok = d_flags[FLAG_RD];
            ACC_WRITE: perm_ok = d_flags[FLAG_WR];
            ACC_EXEC:  perm_ok = d_flags[FLAG_EX];
            default:   perm_ok = 1'b0;
        endcase
    end

    // Priority: invalid, bound, user, permission.
    always_comb begin
        if (!d_valid) begin
            cause = FLT_INVALID;
        end else if (off_ext >= d_bound) begin
            cause = FLT_BOUND;
        end else if (user && !d_flags[FLAG_USR]) begin
            cause = FLT_USER;
        end else if (!perm_ok) begin
            cause = FLT_PERM;
        end else begin
            cause = FLT_NONE;
        end
        fault = (cause != FLT_NONE);
        paddr = fault ? '0 : (d_base + PA_W'(off));
    end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
    parameter int IDX_W = 2,
    parameter int OFF_W = 12,
    parameter int PA_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     wr_sup,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic                     wr_valid,
    input  logic [PA_W-1:0]          wr_base,
    input  logic [OFF_W:0]           wr_bound,
    input  logic [3:0]               wr_flags,
    input  logic                     req_valid,
    input  logic [IDX_W+OFF_W-1:0]   req_vaddr,
    input  logic [1:0]               req_acc,
    input  logic                     req_user,
    output logic                     rsp_valid,
    output logic                     rsp_fault,
    output logic [2:0]               rsp_cause,
    output logic [PA_W-1:0]          rsp_paddr
);
    import seg_pkg::*;

    localparam int BND_W = OFF_W + 1;
    localparam int VA_W  = IDX_W + OFF_W;

    typedef struct packed {
        logic            valid;
        logic            fault;
        flt_e            cause;
        logic [PA_W-1:0] paddr;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic                  tab_we;
    logic [IDX_W-1:0]      req_idx;
    logic [OFF_W-1:0]      req_off;
    logic                  lk_valid;
    logic [PA_W-1:0]       lk_base;
    logic [BND_W-1:0]      lk_bound;
    logic [FLAG_W_BITS-1:0] lk_flags;
    logic                  chk_fault;
    flt_e                  chk_cause;
    logic [PA_W-1:0]       chk_paddr;

    assign tab_we  = wr_en && wr_sup;
    assign req_idx = req_vaddr[VA_W-1:OFF_W];
    assign req_off = req_vaddr[OFF_W-1:0];

    seg_table #(.IDX_W(IDX_W), .PA_W(PA_W), .BND_W(BND_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tab_we),
        .wr_idx   (wr_idx),
        .wr_valid (wr_valid),
        .wr_base  (wr_base),
        .wr_bound (wr_bound),
        .wr_flags (wr_flags),
        .rd_idx   (req_idx),
        .rd_valid (lk_valid),
        .rd_base  (lk_base),
        .rd_bound (lk_bound),
        .rd_flags (lk_flags)
    );

    seg_check #(.OFF_W(OFF_W), .PA_W(PA_W), .BND_W(BND_W)) u_check (
        .off     (req_off),
        .acc     (acc_e'(req_acc)),
        .user    (req_user),
        .d_valid (lk_valid),
        .d_base  (lk_base),
        .d_bound (lk_bound),
        .d_flags (lk_flags),
        .fault   (chk_fault),
        .cause   (chk_cause),
        .paddr   (chk_paddr)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            rsp_d.fault = chk_fault;
            rsp_d.cause = chk_cause;
            rsp_d.paddr = chk_paddr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_fault = rsp_q.fault;
    assign rsp_cause = rsp_q.cause;
    assign rsp_paddr = rsp_q.paddr;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int OFF_W = 12,
    parameter int PA_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [OFF_W-1:0] req_off,
    input logic             lk_valid,
    input logic [OFF_W:0]   lk_bound,
    input logic             rsp_valid,
    input logic             rsp_fault,
    input logic [2:0]       rsp_cause,
    input logic [PA_W-1:0]  rsp_paddr
);
    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_idle_no_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_fault_matches_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault == (rsp_cause != 3'd0)));

    assert_fault_zero_addr_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

    assert_invalid_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !lk_valid) |=> (rsp_fault && rsp_cause == 3'd1));

    assert_bound_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && lk_valid && ({1'b0, req_off} >= lk_bound)) |=> (rsp_fault && rsp_cause == 3'd2));

endmodule

bind seg_xlate seg_xlate_chk #(.OFF_W(OFF_W), .PA_W(PA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_off   (req_vaddr[OFF_W-1:0]),
    .lk_valid  (lk_valid),
    .lk_bound  (lk_bound),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_cause (rsp_cause),
    .rsp_paddr (rsp_paddr)
);

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W = 2;
    localparam int OFF_W = 12;
    localparam int PA_W  = 16;
    localparam int NENT  = 1 << IDX_W;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   wr_en = 1'b0, wr_sup = 1'b0, wr_valid = 1'b0;
    logic [IDX_W-1:0]       wr_idx = '0;
    logic [PA_W-1:0]        wr_base = '0;
    logic [OFF_W:0]         wr_bound = '0;
    logic [3:0]             wr_flags = '0;
    logic                   req_valid = 1'b0, req_user = 1'b0;
    logic [IDX_W+OFF_W-1:0] req_vaddr = '0;
    logic [1:0]             req_acc = '0;
    logic                   rsp_valid, rsp_fault;
    logic [2:0]             rsp_cause;
    logic [PA_W-1:0]        rsp_paddr;

    int checks = 0;
    int fails  = 0;

    // behavioural descriptor model
    bit m_valid [NENT];
    int m_base  [NENT];
    int m_bound [NENT];
    int m_flags [NENT];

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_xlate #(.IDX_W(IDX_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sup(wr_sup), .wr_idx(wr_idx), .wr_valid(wr_valid),
        .wr_base(wr_base), .wr_bound(wr_bound), .wr_flags(wr_flags),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_acc(req_acc), .req_user(req_user),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic check(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic set_wr(bit sup, int idx, bit v, int base, int bound, int flags);
        wr_en = 1'b1; wr_sup = sup; wr_idx = IDX_W'(idx); wr_valid = v;
        wr_base = PA_W'(base); wr_bound = (OFF_W+1)'(bound); wr_flags = 4'(flags);
    endtask

    task automatic set_req(int idx, int off, int acc, bit usr);
        req_valid = 1'b1;
        req_vaddr = (IDX_W+OFF_W)'((idx << OFF_W) | off);
        req_acc = 2'(acc); req_user = usr;
    endtask

    // One clock: model computes expected from old table, then applies write.
    task automatic step(string tag);
        int idx, off, cause, pa, fl;
        bit ev, perm;
        ev = req_valid;
        idx = int'(req_vaddr) >> OFF_W;
        off = int'(req_vaddr) & ((1 << OFF_W) - 1);
        fl = m_flags[idx];
        case (int'(req_acc))
            0: perm = fl[0];
            1: perm = fl[1];
            2: perm = fl[2];
            default: perm = 1'b0;
        endcase
        if (!m_valid[idx])                 cause = 1;
        else if (off >= m_bound[idx])      cause = 2;
        else if (req_user && !fl[3])       cause = 4;
        else if (!perm)                    cause = 3;
        else                               cause = 0;
        pa = (cause == 0) ? ((m_base[idx] + off) % (1 << PA_W)) : 0;
        if (wr_en && wr_sup) begin
            m_valid[int'(wr_idx)] = wr_valid;
            m_base[int'(wr_idx)]  = int'(wr_base);
            m_bound[int'(wr_idx)] = int'(wr_bound);
            m_flags[int'(wr_idx)] = int'(wr_flags);
        end
        @(posedge clk);
        #1;
        check(tag, int'(rsp_valid), int'(ev), "rsp_valid");
        if (ev) begin
            check(tag, int'(rsp_cause), cause, "rsp_cause");
            check(tag, int'(rsp_fault), int'(cause != 0), "rsp_fault");
            check(tag, int'(rsp_paddr), pa, "rsp_paddr");
        end
        wr_en = 1'b0; wr_sup = 1'b0; req_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < NENT; i++) begin
            m_valid[i] = 0; m_base[i] = 0; m_bound[i] = 0; m_flags[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1;
        check("R1", int'(rsp_valid), 0, "rsp_valid in reset");
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1", int'(rsp_valid), 0, "rsp_valid after reset");

        // R1/R7: all entries invalid after reset
        for (int i = 0; i < NENT; i++) begin
            set_req(i, 5, 0, 1'b0); step("R1");
        end

        // R11: write-only cycle, no response
        set_wr(1, 0, 1, 'h1000, 'h800, 'b1011); step("R11");
        // R2: translation
        set_req(0, 'h123, 0, 1'b0); step("R2");
        set_req(0, 'h7FF, 1, 1'b1); step("R2");
        // R3: bound edge
        set_req(0, 'h800, 0, 1'b0); step("R3");
        set_req(0, 'hFFF, 0, 1'b0); step("R3");

        // seg1: full length, read-only, supervisor-only
        set_wr(1, 1, 1, 'h8000, 'h1000, 'b0001); step("R3");
        set_req(1, 'hFFF, 0, 1'b0); step("R3");
        set_req(1, 'h010, 1, 1'b0); step("R4");
        set_req(1, 'h010, 2, 1'b0); step("R5");
        set_req(1, 'h010, 3, 1'b0); step("R5");
        set_req(1, 'h010, 0, 1'b1); step("R6");
        set_req(1, 'h010, 1, 1'b1); step("R8");

        // seg2: wrap, exec + read + user
        set_wr(1, 2, 1, 'hF800, 'h1000, 'b1101); step("R13");
        set_req(2, 'h900, 2, 1'b1); step("R13");
        set_req(2, 'h900, 1, 1'b1); step("R4");
        set_req(2, 'h7FF, 2, 1'b0); step("R6");

        // seg3: tiny, no flags
        set_wr(1, 3, 1, 'h0, 'h10, 'b0000); step("R8");
        set_req(3, 'h20, 1, 1'b1); step("R8");
        set_req(3, 'h05, 1, 1'b1); step("R8");
        set_req(3, 'h05, 1, 1'b0); step("R12");

        // R9: unprivileged write ignored
        set_wr(0, 3, 1, 'h0, 'h10, 'b1111); step("R9");
        set_req(3, 'h05, 0, 1'b0); step("R9");

        // R10: same-cycle write uses old contents, next sees new
        set_wr(1, 3, 1, 'h0, 'h10, 'b0001);
        set_req(3, 'h05, 0, 1'b0); step("R10");
        set_req(3, 'h05, 0, 1'b0); step("R10");
        set_wr(1, 0, 0, 'h1000, 'h800, 'b1011);
        set_req(0, 'h10, 0, 1'b0); step("R10");
        set_req(0, 'h10, 0, 1'b0); step("R7");

        // R3: zero bound faults all offsets
        set_wr(1, 0, 1, 'h1234, 'h0, 'b1111); step("R3");
        set_req(0, 'h0, 0, 1'b0); step("R3");

        // R2: mixed traffic
        for (int n = 0; n < 300; n++) begin
            if ($urandom() % 4 == 0)
                set_wr($urandom() % 8 != 0, $urandom() % NENT, $urandom() % 8 != 0,
                       $urandom() % (1 << PA_W), $urandom() % ((1 << OFF_W) + 1), $urandom() % 16);
            if ($urandom() % 5 != 0)
                set_req($urandom() % NENT, $urandom() % (1 << OFF_W), $urandom() % 4, $urandom() % 2 == 0);
            step("R2");
        end

        summary();
        $finish;
    end

endmodule